// File: doc/BRIEF.md
# Predicated Vector Index Generator

The block writes a vector register of `LANES` 32-bit integer lanes (64 by default) with a run of consecutive indices. The run begins at a 32-bit scalar seed. Each lane adds one to the lane before it, or takes one away, depending on a two-bit order code given with the request. Software-visible uses such as initialising index buffers are built on top of this block. Address generation and sorting belong elsewhere.

A per-lane predicate mask picks the lanes that receive the generated value. For the lanes the mask leaves out, a mode input decides what they get: either zero, or the matching lane of an old-destination vector supplied with the request. A request is taken on any cycle that has `req_valid` high. Its result appears in the result register one clock later, together with a single-cycle `done` pulse, so requests can arrive back to back. An order code that is not one of the two legal ones raises `err` for one cycle and leaves the register as it was.

Top module: `vidx_gen`

## Requirements
- R1: With order code 2'b00 (rising), active lane i (bits 32i+31 down to 32i of `result`) holds seed + i modulo 2^32, for i from 0 to LANES-1.
- R2: With order code 2'b01 (falling), active lane i holds seed − i modulo 2^32, and wraps to two's-complement negative values without saturation (seed 63 over 64 lanes gives 63 down to 0).
- R3: Order codes 2'b10 and 2'b11 are illegal: the cycle after such a request `err` is 1, `done` is 0 and `result` is unchanged.
- R4: A legal request sampled on a rising edge updates `result` and pulses `done` high on that same edge, so both are visible one clock after the request. `done` falls on the next edge unless another legal request is present. Consecutive requests on consecutive cycles each produce their own result.
- R5: A lane whose `lane_mask` bit is 1 takes the generated value.
- R6: With `merge_en` = 0, a lane whose mask bit is 0 becomes zero.
- R7: With `merge_en` = 1, a lane whose mask bit is 0 takes lane i of `old_dst` (same bit positions as in `result`).
- R8: The result depends only on the current request's inputs. Repeating a request gives an identical vector, whatever requests came in between.
- R9: While `rst_n` is 0 at a rising edge, `result`, `done` and `err` are cleared to zero on that edge.
- R10: With no request, `result` holds its value, and `done` and `err` are 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Request strobe, one request per cycle |
| seed | input | 32 | Starting index for lane 0 |
| order_sel | input | 2 | 00 rising, 01 falling, 10/11 illegal |
| lane_mask | input | LANES | Per-lane predicate, 1 = active |
| merge_en | input | 1 | 0 zeroes inactive lanes, 1 copies `old_dst` into them |
| old_dst | input | 32*LANES | Previous destination contents for merging |
| result | output | 32*LANES | Result vector register |
| done | output | 1 | One-cycle pulse when a legal request has been written |
| err | output | 1 | One-cycle pulse when an illegal order code was rejected |

## Verification
The bench targets arithmetic wrap at both ends of the 32-bit range: a falling run from a small seed and a rising run from near 2^32−1. A design that saturated, or sign-handled those lanes, would show wrong values in the upper lanes. Illegal codes are sent between legal requests, so a design that decoded only one order bit would write a falling or rising vector where the old contents should have stayed, and `err` would stay low. Sparse and dense masks are tried in both zeroing and merging modes, which exposes swapped mode polarity or a lane offset in the merge path. Back-to-back streams and a repeated request check that nothing leaks from one request into the next, and a reset in the middle of the run checks that every registered output clears.

// File: rtl/vidx_pkg.sv
// Package: shared constants and order-code type for the vector index generator.
// Assumes every lane is a fixed 32-bit two's-complement integer.
package vidx_pkg;

    localparam int unsigned LANE_W = 32;

    typedef enum logic [1:0] {
        ORD_RISE  = 2'b00,
        ORD_FALL  = 2'b01,
        ORD_RSV_A = 2'b10,
        ORD_RSV_B = 2'b11
    } order_e;

endpackage

// File: rtl/vidx_order_dec.sv
// Module: vidx_order_dec
// Decodes the two-bit order code into a legality flag and a direction flag.
// Assumes the code is sampled with the request; no state is held here.
module vidx_order_dec
    import vidx_pkg::*;
(
    input  logic [1:0] order_code,
    output logic       legal,
    output logic       falling
);

    order_e code_e;

    // Classify the incoming code against the two legal encodings.
    always_comb begin
        code_e  = order_e'(order_code);
        legal   = 1'b0;
        falling = 1'b0;
        case (code_e)
            ORD_RISE: begin
                legal   = 1'b1;
                falling = 1'b0;
            end
            ORD_FALL: begin
                legal   = 1'b1;
                falling = 1'b1;
            end
            default: begin
                legal   = 1'b0;
                falling = 1'b0;
            end
        endcase
    end

endmodule

// File: rtl/vidx_lane_ramp.sv
// Module: vidx_lane_ramp
// Produces the unmasked ramp: lane i is seed + i or seed - i, modulo 2^W.
// Assumes LANES fits in W bits; each lane has its own adder with a constant operand.
module vidx_lane_ramp #(
    parameter int unsigned LANES = 64,
    parameter int unsigned W     = vidx_pkg::LANE_W
) (
    input  logic [W-1:0]       seed,
    input  logic               falling,
    output logic [LANES*W-1:0] ramp
);

    localparam int unsigned VEC_W = LANES * W;

    logic [VEC_W-1:0] ramp_up;
    logic [VEC_W-1:0] ramp_dn;

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        localparam logic [W-1:0] OFFS = W'(g);

        // Rising and falling candidates for this lane; both wrap freely.
        always_comb begin
            ramp_up[g*W +: W] = seed + OFFS;
            ramp_dn[g*W +: W] = seed - OFFS;
        end
    end

    // Pick the direction for the whole vector.
    always_comb begin
        ramp = falling ? ramp_dn : ramp_up;
    end

endmodule

// File: rtl/vidx_lane_pred.sv
// Module: vidx_lane_pred
// Applies the per-lane predicate: active lanes take the ramp, inactive lanes
// take zero or the old destination lane depending on the merge flag.
// Assumes the old destination uses the same lane packing as the ramp.
module vidx_lane_pred #(
    parameter int unsigned LANES = 64,
    parameter int unsigned W     = vidx_pkg::LANE_W
) (
    input  logic [LANES*W-1:0] ramp,
    input  logic [LANES-1:0]   mask,
    input  logic               merge,
    input  logic [LANES*W-1:0] old_vec,
    output logic [LANES*W-1:0] vec_out
);

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        logic [W-1:0] fill;

        // Value for an inactive lane.
        always_comb begin
            fill = merge ? old_vec[g*W +: W] : '0;
        end

        // Choose between generated and fill value.
        always_comb begin
            vec_out[g*W +: W] = mask[g] ? ramp[g*W +: W] : fill;
        end
    end

endmodule

// File: rtl/vidx_gen.sv
// Module: vidx_gen (top)
// Vector index generator: on each valid request with a legal order code the
// predicated ramp is written into the result register and done pulses; an
// illegal code pulses err and leaves the register alone.
// Assumes synchronous active-low reset and one request per clock at most.
module vidx_gen #(
    parameter int unsigned LANES = 64,
    parameter int unsigned W     = vidx_pkg::LANE_W
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               req_valid,
    input  logic [W-1:0]       seed,
    input  logic [1:0]         order_sel,
    input  logic [LANES-1:0]   lane_mask,
    input  logic               merge_en,
    input  logic [LANES*W-1:0] old_dst,
    output logic [LANES*W-1:0] result,
    output logic               done,
    output logic               err
);

    localparam int unsigned VEC_W = LANES * W;

    logic             code_ok;
    logic             code_fall;
    logic [VEC_W-1:0] ramp_vec;
    logic [VEC_W-1:0] next_vec;
    logic [VEC_W-1:0] result_q;
    logic             done_q;
    logic             err_q;
    logic             take;
    logic             reject;

    vidx_order_dec u_dec (
        .order_code (order_sel),
        .legal      (code_ok),
        .falling    (code_fall)
    );

    vidx_lane_ramp #(.LANES(LANES), .W(W)) u_ramp (
        .seed    (seed),
        .falling (code_fall),
        .ramp    (ramp_vec)
    );

    vidx_lane_pred #(.LANES(LANES), .W(W)) u_pred (
        .ramp    (ramp_vec),
        .mask    (lane_mask),
        .merge   (merge_en),
        .old_vec (old_dst),
        .vec_out (next_vec)
    );

    // Split a request into an accepted write or a rejection.
    always_comb begin
        take   = req_valid & code_ok;
        reject = req_valid & ~code_ok;
    end

    // Result register: cleared by reset, loaded only on an accepted request.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            result_q <= '0;
        end else if (take) begin
            result_q <= next_vec;
        end
    end

    // Completion and error pulses, each one cycle wide per request.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            done_q <= 1'b0;
            err_q  <= 1'b0;
        end else begin
            done_q <= take;
            err_q  <= reject;
        end
    end

    assign result = result_q;
    assign done   = done_q;
    assign err    = err_q;

endmodule

// File: rtl/vidx_gen_chk.sv
// Module: vidx_gen_chk
// Property checker for vidx_gen, attached by bind. Looks at lane 0 and the
// last lane plus the control pulses.
module vidx_gen_chk #(
    parameter int unsigned W = 32
) (
    input logic         clk,
    input logic         rst_n,
    input logic         req_valid,
    input logic [W-1:0] seed,
    input logic [1:0]   order_sel,
    input logic         mask0,
    input logic         merge_en,
    input logic [W-1:0] old0,
    input logic [W-1:0] res0,
    input logic [W-1:0] res_top,
    input logic         done,
    input logic         err
);

    AST_RESET_CLEARS: assert property (@(posedge clk)
        !rst_n |=> (res0 == '0 && res_top == '0 && !done && !err)); // R9

    AST_DONE_NEXT: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !order_sel[1]) |=> (done && !err)); // R4

    AST_ILLEGAL_ERR: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && order_sel[1]) |=> (err && !done)); // R3

    AST_ILLEGAL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && order_sel[1]) |=> ($stable(res0) && $stable(res_top))); // R3

    AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !req_valid |=> ($stable(res0) && $stable(res_top) && !done && !err)); // R10

    AST_LANE0_SEED: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !order_sel[1] && mask0) |=> (res0 == $past(seed))); // R5

    AST_ZERO_FILL: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !order_sel[1] && !mask0 && !merge_en) |=> (res0 == '0)); // R6

    AST_MERGE_FILL: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !order_sel[1] && !mask0 && merge_en) |=> (res0 == $past(old0))); // R7

    AST_PULSE_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
        !(done && err)); // R3

endmodule

bind vidx_gen vidx_gen_chk #(.W(W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_valid (req_valid),
    .seed      (seed),
    .order_sel (order_sel),
    .mask0     (lane_mask[0]),
    .merge_en  (merge_en),
    .old0      (old_dst[W-1:0]),
    .res0      (result[W-1:0]),
    .res_top   (result[LANES*W-1 -: W]),
    .done      (done),
    .err       (err)
);

// File: tb/vidx_gen_tb.sv
// Bench for vidx_gen: behavioural reference model updated on every rising
// edge, compared against the outputs on every falling edge.
module vidx_gen_tb;

    localparam int N = 64;
    localparam int W = 32;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             req_valid = 1'b0;
    logic [W-1:0]     seed = '0;
    logic [1:0]       order_sel = 2'b00;
    logic [N-1:0]     lane_mask = '0;
    logic             merge_en = 1'b0;
    logic [N*W-1:0]   old_dst = '0;
    logic [N*W-1:0]   result;
    logic             done;
    logic             err;

    int compared = 0;
    int mismatched = 0;
    bit finished = 0;

    // Reference state.
    logic [W-1:0] m_res [N];
    logic         m_done = 1'b0;
    logic         m_err  = 1'b0;
    string        m_tag  = "R9";

    always #2 clk = ~clk; // 250 MHz

    vidx_gen #(.LANES(N), .W(W)) u_dut (
        .clk       (clk),
        .rst_n     (rst_n),
        .req_valid (req_valid),
        .seed      (seed),
        .order_sel (order_sel),
        .lane_mask (lane_mask),
        .merge_en  (merge_en),
        .old_dst   (old_dst),
        .result    (result),
        .done      (done),
        .err       (err)
    );

    initial begin
        for (int i = 0; i < N; i++) m_res[i] = '0;
    end

    // Reference model: written from the requirements, lane by lane.
    always @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < N; i++) m_res[i] = '0;
            m_done = 0; m_err = 0; m_tag = "R9";
        end else if (req_valid && (order_sel == 2'b00 || order_sel == 2'b01)) begin
            for (int i = 0; i < N; i++) begin
                logic [W-1:0] v;
                v = (order_sel == 2'b00) ? seed + W'(i) : seed - W'(i);
                if (!lane_mask[i]) v = merge_en ? old_dst[i*W +: W] : '0;
                m_res[i] = v;
            end
            m_done = 1; m_err = 0;
            m_tag = (lane_mask != '1) ? (merge_en ? "R7" : "R6")
                                      : (order_sel == 2'b00 ? "R1" : "R2");
        end else if (req_valid) begin
            m_done = 0; m_err = 1; m_tag = "R3";
        end else begin
            m_done = 0; m_err = 0; m_tag = "R10";
        end
    end

    task automatic check_bit(input string tag, input logic act, input logic exp);
        compared++;
        if (act !== exp) begin
            mismatched++;
            $display("FAIL %s: got %b expected %b", tag, act, exp);
        end
    endtask

    // Compare all outputs with the model.
    task automatic compare_all();
        int bad;
        bad = -1;
        for (int i = 0; i < N; i++)
            if (bad < 0 && result[i*W +: W] !== m_res[i]) bad = i;
        compared++;
        if (bad >= 0) begin
            mismatched++;
            $display("FAIL %s: lane %0d got %h expected %h", m_tag, bad,
                     result[bad*W +: W], m_res[bad]);
        end
        check_bit("R4 done", done, m_done);
        check_bit("R3 err", err, m_err);
    endtask

    // One cycle: compare, then set up next inputs.
    task automatic step(input logic v, input logic [W-1:0] s, input logic [1:0] o,
                        input logic [N-1:0] m, input logic mg, input logic [N*W-1:0] od);
        @(negedge clk);
        compare_all();
        req_valid = v; seed = s; order_sel = o; lane_mask = m; merge_en = mg; old_dst = od;
    endtask

    function automatic logic [N*W-1:0] old_pat(input logic [W-1:0] salt);
        logic [N*W-1:0] r;
        for (int i = 0; i < N; i++) r[i*W +: W] = 32'hA5000000 ^ salt ^ W'(i * 7);
        return r;
    endfunction

    task automatic idle();
        step(1'b0, 32'hDEADBEEF, 2'b01, '1, 1'b0, '0);
    endtask

    logic [N*W-1:0] snap;

    initial begin
        logic [N-1:0] alt;
        alt = {(N/2){2'b01}};
        rst_n = 0;
        repeat (2) idle();
        // R9 reset state
        @(negedge clk);
        check_bit("R9 done", done, 1'b0);
        check_bit("R9 err", err, 1'b0);
        compared++;
        if (result !== '0) begin
            mismatched++;
            $display("FAIL R9: result %h expected 0", result[W-1:0]);
        end
        rst_n = 1;
        idle();
        step(1, 32'd0, 2'b00, '1, 0, '0);                 // R1 from 0
        step(1, 32'd63, 2'b01, '1, 0, '0);                // R2 63..0
        step(1, 32'd5, 2'b01, '1, 0, '0);                 // R2 wrap negative
        step(1, 32'hFFFFFFF0, 2'b00, '1, 0, '0);          // R1 wrap past max
        step(1, 32'h1234, 2'b10, '1, 0, '0);              // R3 illegal
        step(1, 32'h5678, 2'b11, '0, 1, old_pat(1));      // R3 illegal
        idle(); idle();                                   // R10 hold
        step(1, 32'd100, 2'b00, alt, 0, old_pat(2));      // R5/R6
        step(1, 32'd100, 2'b01, ~alt, 1, old_pat(3));     // R5/R7
        step(1, 32'd7, 2'b00, '0, 1, old_pat(4));         // R7 all inactive
        step(1, 32'd7, 2'b01, '0, 0, old_pat(4));         // R6 all zero
        step(1, 32'h80000000, 2'b00, 64'h8000_0000_0000_0001, 1, old_pat(5)); // R5 ends
        // R4 back-to-back random stream
        for (int k = 0; k < 40; k++) begin
            logic [1:0] o;
            o = 2'($urandom_range(0, 3));
            step(1, $urandom(), o, {$urandom(), $urandom()}, 1'($urandom()),
                 old_pat($urandom()));
        end
        // R8 repeat a request with others between
        step(1, 32'd42, 2'b01, alt, 1, old_pat(9));
        @(negedge clk); snap = result;
        compare_all();
        req_valid = 1; seed = 32'd1; order_sel = 2'b00; lane_mask = '1; merge_en = 0;
        step(1, 32'd42, 2'b01, alt, 1, old_pat(9));
        idle();
        compared++;
        if (result !== snap) begin
            mismatched++;
            $display("FAIL R8: lane0 got %h expected %h", result[W-1:0], snap[W-1:0]);
        end
        // R9 reset mid-run
        step(1, 32'd9, 2'b00, '1, 0, '0);
        rst_n = 0;
        idle();
        rst_n = 1;
        idle(); idle();
        @(negedge clk);
        compare_all();
        finished = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
    end

    // Watchdog: ends a hung run as a failure.
    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            mismatched++;
            $display("FAIL R4: watchdog expired, got hang expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
            $finish;
        end
    end

endmodule